// File: doc/BRIEF.md
# Dual-Host Edge Interrupt Bank

This block gathers up to two dozen level inputs into one interrupt bank that two hosts share. Every input passes through a two-stage synchronizer and a per-input edge detector that can be set to rising, falling, both or neither. Each detected edge latches a status bit in two independent copies, one per host line. Each host has its own mask, its own active-low interrupt output and its own active-high summary bit for a primary aggregator.

Software reaches the bank through a byte-wide register port with address, read strobe, write strobe and data. A control byte picks the way status clears. In one mode, reading a status byte clears it. In the other, writing ones clears the chosen bits. The same byte can enable a one-deep buffer per bit, so that a second edge that arrives while the bit is still set is not lost. A test register sets status bits directly on both lines.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, both `irq_n` outputs are high, every status bit, edge-select bit and control bit is 0, and every valid mask bit is 1.
- R2: Input i owns the 2-bit field at bits [2*(i%4)+1 : 2*(i%4)] of edge-select byte i/4. The upper bit of the field enables rising-edge detection and the lower bit enables falling-edge detection. With both bits set, either edge sets status.
- R3: An input whose two edge-select bits are both 0 never sets status, whatever its level does.
- R4: A detected edge sets the input's status bit on both lines. Each line clears its own copy without touching the other.
- R5: With control bit 0 clear, writing a status byte clears the bits written as 1 and leaves the others unchanged. Reads do not clear status.
- R6: With control bit 0 set, a read of a status byte returns the byte and clears its bits. Writes to status are then ignored.
- R7: `irq_n[l]` is low while line l has any status bit set whose mask bit is 0. A mask bit of 1 blocks its input. The output rises in the cycle after the register access that removes the last such bit.
- R8: Status and mask bits at or above the input count (bits 7:4 of byte 2 with 20 inputs) read as 0.
- R9: With control bit 1 set, an edge that arrives while its status bit is set is held. After the clear the bit reads 1 again, and a further clear takes it to 0. With control bit 1 clear, such an edge is lost.
- R10: Writing a byte to the test register sets the status bits written as 1 on both lines.
- R11: An input change applied before rising clock edge k is visible in status, and hence on `irq_n`, from edge k+2 onward and not earlier.
- R12: Register map with NB = ceil(N/8) and NE = ceil(2N/8):
  - status line 0 at 0..NB-1, mask line 0 next, then status line 1, then mask line 1;
  - edge select at 4NB..4NB+NE-1;
  - control at 4NB+NE;
  - test at the NB bytes after control, which read as 0.

  Read data appears on the clock edge that samples `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_IN | Asynchronous interrupt source levels |
| reg_addr | input | ADDR_W | Register byte address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt per host line |
| irq_summary | output | 2 | Active-high pending summary per line |

## Verification
The assertions take two things for granted about the inputs. First, a read strobe and a write strobe never fall in the same cycle. Second, the source levels are held low while reset is active, so the synchronizer does not report a false edge as reset releases. The stimulus drives every strobe as a single-cycle pulse on the falling clock edge, one access at a time. It changes a source only after the previous change has passed through the synchronizer, so a later edge is never folded into an earlier one.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    typedef struct packed {
        logic buf_en;   // bit 1: hold a second pending edge
        logic cor;      // bit 0: status clears on read
    } ctrl_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STS_A,
        REG_MSK_A,
        REG_STS_B,
        REG_MSK_B,
        REG_EDGE,
        REG_CTRL,
        REG_TEST
    } reg_kind_e;

endpackage

// File: rtl/irqb_edge_detect.sv
module irqb_edge_detect #(
    parameter int N_IN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   din,
    input  logic [2*N_IN-1:0] cfg,
    output logic [N_IN-1:0]   ev
);

    typedef struct packed {
        logic [N_IN-1:0] s1;
        logic [N_IN-1:0] s2;
        logic [N_IN-1:0] prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_det
        logic rise_i, fall_i;
        assign rise_i = st_q.s2[i] & ~st_q.prev[i];
        assign fall_i = ~st_q.s2[i] & st_q.prev[i];
        assign ev[i]  = (rise_i & cfg[2*i+1]) | (fall_i & cfg[2*i]);
    end

endmodule

// File: rtl/irqb_line_state.sv
module irqb_line_state #(
    parameter int N_IN  = 20,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  ev,
    input  logic [N_IN-1:0]  tset,
    input  logic             cor,
    input  logic             buf_en,
    input  logic             sts_rd,
    input  logic             sts_wr,
    input  logic             msk_wr,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       wdata,
    output logic [N_IN-1:0]  sts,
    output logic [N_IN-1:0]  msk,
    output logic             irq_n,
    output logic             summary
);

    localparam int NB = (N_IN + 7) / 8;
    localparam int W  = NB * 8;

    typedef struct packed {
        logic [N_IN-1:0] sts;
        logic [N_IN-1:0] msk;
        logic [N_IN-1:0] pend;
    } line_st_t;

    line_st_t st_q, st_d;

    logic [N_IN-1:0] wvec, bvec, clr_vec, set_vec, live;

    assign wvec    = N_IN'(W'(wdata) << (8 * byte_idx));
    assign bvec    = N_IN'(W'(8'hFF) << (8 * byte_idx));
    assign set_vec = ev | tset;

    always_comb begin
        clr_vec = '0;
        if (sts_wr && !cor)     clr_vec = wvec;
        else if (sts_rd && cor) clr_vec = bvec;

        st_d      = st_q;
        st_d.sts  = (st_q.sts & ~clr_vec) | set_vec | (st_q.pend & clr_vec);
        st_d.pend = st_q.pend & ~clr_vec;
        if (buf_en) st_d.pend = st_d.pend | (set_vec & st_q.sts & ~clr_vec);
        if (msk_wr) st_d.msk = (st_q.msk & ~bvec) | (wvec & bvec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts  <= '0;
            st_q.msk  <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live    = st_q.sts & ~st_q.msk;
    assign irq_n   = ~|live;
    assign summary = |live;
    assign sts     = st_q.sts;
    assign msk     = st_q.msk;

    // R4: a status bit only rises when an edge or test write asked for it
    assert_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts != $past(st_q.sts)) |->
        ((st_q.sts & ~$past(st_q.sts) & ~$past(set_vec)) == '0));

    // R5: write-one-to-clear removes the written bits unless re-set or held
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !cor) |=>
        ((st_q.sts & $past(wvec) & ~$past(set_vec | st_q.pend)) == '0));

    // R6: clear-on-read empties the byte that was read
    assert_cor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && cor) |=>
        ((st_q.sts & $past(bvec) & ~$past(set_vec | st_q.pend)) == '0));

    // R7: the output only releases after a register access
    assert_release_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(sts_rd || sts_wr || msk_wr));

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqb_pkg::*;
#(
    parameter int N_IN   = 20,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   irq_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        irq_n,
    output logic [1:0]        irq_summary
);

    localparam int NB     = (N_IN + 7) / 8;
    localparam int NE     = (2 * N_IN + 7) / 8;
    localparam int CFG_W  = 2 * N_IN;
    localparam int PAD_W  = NB * 8;
    localparam int EDG_W  = NE * 8;
    localparam int IDX_W  = $clog2(NE + 1);
    localparam int OFS_MA = NB;
    localparam int OFS_SB = 2 * NB;
    localparam int OFS_MB = 3 * NB;
    localparam int OFS_ED = 4 * NB;
    localparam int OFS_CT = 4 * NB + NE;
    localparam int OFS_TS = OFS_CT + 1;
    localparam int OFS_END = OFS_TS + NB;

    typedef struct packed {
        logic [EDG_W-1:0] edge_sel;
        ctrl_t            ctrl;
        logic [7:0]       rdata;
    } top_st_t;

    top_st_t st_q, st_d;

    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [N_IN-1:0]  ev, tset;
    logic [N_IN-1:0]  sts_l [2];
    logic [N_IN-1:0]  msk_l [2];
    logic [7:0]       rd_byte;

    // address decode
    always_comb begin
        int a;
        a    = int'(reg_addr);
        kind = REG_NONE;
        idx  = '0;
        if (a < OFS_MA) begin
            kind = REG_STS_A; idx = IDX_W'(a);
        end else if (a < OFS_SB) begin
            kind = REG_MSK_A; idx = IDX_W'(a - OFS_MA);
        end else if (a < OFS_MB) begin
            kind = REG_STS_B; idx = IDX_W'(a - OFS_SB);
        end else if (a < OFS_ED) begin
            kind = REG_MSK_B; idx = IDX_W'(a - OFS_MB);
        end else if (a < OFS_CT) begin
            kind = REG_EDGE;  idx = IDX_W'(a - OFS_ED);
        end else if (a == OFS_CT) begin
            kind = REG_CTRL;
        end else if (a < OFS_END) begin
            kind = REG_TEST;  idx = IDX_W'(a - OFS_TS);
        end
    end

    assign tset = (reg_wr && kind == REG_TEST) ?
                  N_IN'(PAD_W'(reg_wdata) << (8 * idx)) : '0;

    // read mux
    always_comb begin
        case (kind)
            REG_STS_A: rd_byte = 8'(PAD_W'(sts_l[0]) >> (8 * idx));
            REG_MSK_A: rd_byte = 8'(PAD_W'(msk_l[0]) >> (8 * idx));
            REG_STS_B: rd_byte = 8'(PAD_W'(sts_l[1]) >> (8 * idx));
            REG_MSK_B: rd_byte = 8'(PAD_W'(msk_l[1]) >> (8 * idx));
            REG_EDGE:  rd_byte = 8'(st_q.edge_sel >> (8 * idx));
            REG_CTRL:  rd_byte = {6'b0, st_q.ctrl};
            default:   rd_byte = 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && kind == REG_EDGE)
            st_d.edge_sel = (st_q.edge_sel & ~(EDG_W'(8'hFF) << (8 * idx)))
                          | (EDG_W'(reg_wdata) << (8 * idx));
        if (reg_wr && kind == REG_CTRL)
            st_d.ctrl = ctrl_t'(reg_wdata[1:0]);
        if (reg_rd)
            st_d.rdata = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    irqb_edge_detect #(.N_IN(N_IN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .cfg   (CFG_W'(st_q.edge_sel)),
        .ev    (ev)
    );

    for (genvar l = 0; l < 2; l++) begin : g_line
        localparam reg_kind_e STS_K = (l == 0) ? REG_STS_A : REG_STS_B;
        localparam reg_kind_e MSK_K = (l == 0) ? REG_MSK_A : REG_MSK_B;
        irqb_line_state #(.N_IN(N_IN), .IDX_W(IDX_W)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev),
            .tset     (tset),
            .cor      (st_q.ctrl.cor),
            .buf_en   (st_q.ctrl.buf_en),
            .sts_rd   (reg_rd && kind == STS_K),
            .sts_wr   (reg_wr && kind == STS_K),
            .msk_wr   (reg_wr && kind == MSK_K),
            .byte_idx (idx),
            .wdata    (reg_wdata),
            .sts      (sts_l[l]),
            .msk      (msk_l[l]),
            .irq_n    (irq_n[l]),
            .summary  (irq_summary[l])
        );
    end

    // R12: read data only changes on a read
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    if (N_IN % 8 != 0) begin : g_unused
        localparam int HI = N_IN % 8;
        // R8: bits beyond the input count read as zero
        assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && (kind == REG_STS_A || kind == REG_STS_B) &&
             idx == IDX_W'(NB - 1)) |=> (reg_rdata[7:HI] == '0));
    end

endmodule

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 20;
    localparam int AW  = 5;
    localparam int SA  = 0;
    localparam int MA  = 3;
    localparam int SB  = 6;
    localparam int MB  = 9;
    localparam int ED  = 12;
    localparam int CT  = 17;
    localparam int TS  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [1:0]    irq_n;
    logic [1:0]    irq_summary;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    irq_bank_ctrl #(.N_IN(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .irq_summary(irq_summary)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(string tag, logic [1:0] e);
        check({tag, " irq_n"}, {6'b0, irq_n}, {6'b0, e});
        check({tag, " summary"}, {6'b0, irq_summary}, {6'b0, ~e});
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(int a, logic [7:0] e, string tag);
        item_t it;
        @(negedge clk);
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        reg_addr = AW'(a);
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic set_in(int i, logic v);
        @(negedge clk);
        irq_in[i] = v;
        repeat (5) @(negedge clk);
    endtask

    // monitor: compare read data one quarter period after the sampling edge
    always @(posedge clk) begin
        item_t got;
        if (reg_rd) begin
            #(CLK_PERIOD / 4);
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12 unexpected read actual %h expected none", reg_rdata);
            end else begin
                got = sb.pop_front();
                check(got.tag, reg_rdata, got.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_irq("R1", 2'b11);
        rd(SA + 0, 8'h00, "R1 status A byte0");
        rd(SB + 1, 8'h00, "R1 status B byte1");
        rd(MA + 0, 8'hFF, "R1 mask A byte0");
        rd(MB + 1, 8'hFF, "R1 mask B byte1");
        rd(ED + 0, 8'h00, "R1 edge byte0");
        rd(CT, 8'h00, "R1 ctrl");
        rd(MA + 2, 8'h0F, "R8 mask A top byte");

        // R3 edge select off
        set_in(0, 1'b1);
        set_in(0, 1'b0);
        rd(SA + 0, 8'h00, "R3 disabled input");

        // R2 input0 rising only, input1 falling only
        wr(ED + 0, 8'h06);
        rd(ED + 0, 8'h06, "R12 edge readback");
        @(negedge clk);
        irq_in[1:0] = 2'b11;
        repeat (5) @(negedge clk);
        rd(SA + 0, 8'h01, "R2 rising only");
        @(negedge clk);
        irq_in[1:0] = 2'b00;
        repeat (5) @(negedge clk);
        rd(SA + 0, 8'h03, "R2 falling only");
        rd(SA + 0, 8'h03, "R5 read does not clear");
        rd(SB + 0, 8'h03, "R4 line B copy");

        // R2 both edges on input5 (byte1 bits 3:2)
        wr(ED + 1, 8'h0C);
        set_in(5, 1'b1);
        wr(SA + 0, 8'h20);
        rd(SA + 0, 8'h03, "R5 w1c bit5");
        rd(SB + 0, 8'h23, "R4 line B untouched");
        set_in(5, 1'b0);
        rd(SA + 0, 8'h23, "R2 both edges");
        wr(SA + 0, 8'h01);
        rd(SA + 0, 8'h22, "R5 zero bits kept");

        // R7 masking
        chk_irq("R7 all masked", 2'b11);
        wr(MA + 0, 8'hFD);
        chk_irq("R7 unmasked bit1", 2'b10);
        rd(MA + 0, 8'hFD, "R7 mask readback");
        rd(MA + 1, 8'hFF, "R7 other mask byte");
        wr(SA + 0, 8'h02);
        chk_irq("R7 release", 2'b11);

        // R6 clear on read
        wr(CT, 8'h01);
        rd(CT, 8'h01, "R12 ctrl readback");
        rd(SA + 0, 8'h20, "R6 read returns");
        rd(SA + 0, 8'h00, "R6 read cleared");
        wr(SB + 0, 8'hFF);
        rd(SB + 0, 8'h23, "R6 write ignored");
        rd(SB + 0, 8'h00, "R6 line B cleared");

        // R9 without buffering: second edge lost
        set_in(0, 1'b1);
        set_in(0, 1'b0);
        set_in(0, 1'b1);
        rd(SA + 0, 8'h01, "R9 first edge");
        rd(SA + 0, 8'h00, "R9 second edge lost");

        // R9 with buffering on line B (bit0 still set there)
        wr(CT, 8'h03);
        set_in(0, 1'b0);
        set_in(0, 1'b1);
        rd(SB + 0, 8'h01, "R9 held read1");
        rd(SB + 0, 8'h01, "R9 held reappears");
        rd(SB + 0, 8'h00, "R9 held drained");
        rd(SA + 0, 8'h01, "R9 line A single");
        rd(SA + 0, 8'h00, "R9 line A cleared");

        // R10 test register
        wr(TS + 2, 8'hFF);
        rd(SA + 2, 8'h0F, "R10 line A set R8 top bits");
        rd(SB + 2, 8'h0F, "R10 line B set");
        rd(TS + 2, 8'h00, "R12 test reads zero");

        // R11 synchronizer latency on line B
        set_in(0, 1'b0);
        wr(MB + 0, 8'hFE);
        chk_irq("R11 idle", 2'b11);
        @(negedge clk);
        irq_in[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #(CLK_PERIOD / 4);
        chk_irq("R11 not yet", 2'b11);
        @(posedge clk);
        #(CLK_PERIOD / 4);
        chk_irq("R11 visible", 2'b01);
        rd(SB + 0, 8'h01, "R6 read line B");
        chk_irq("R7 release after read", 2'b11);
        rd(SA + 0, 8'h01, "R4 line A still set");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R12 pending reads actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule